// File: doc/BRIEF.md
# Fixed-Priority Bus Ownership Arbiter with Locked Sequences

This block decides which of several masters drives one shared external bus. Master 0 is the CPU, which has the lowest priority and owns the bus whenever nobody else asks for it. The remaining masters are DMA-type engines at fixed priorities. In the default build, index 3 is the DMA controller, index 2 is the external DMA controller, and index 1 is the transfer controller.

A waiting request with higher priority never takes the bus at once. It waits for a legal release point of the current owner. A release point is a bus-cycle end that is not part of an indivisible sequence. Examples of such sequences are the halves of a longword split over a narrow bus, and a read-modify-write.

The transfer controller also reports its phase. In its two register-information phases, it may give up the bus only once it has owned the bus for a set number of states. When the CPU sleeps, it hands the bus over without waiting for any boundary.

Top module: `bus_owner_arbiter`

## Requirements
- R1: While reset is active, and on the first edge after it, `grant` is 4'b0001 (CPU).
- R2: `grant` always has exactly one bit set.
- R3: On a handover, the new owner is the requester with the highest index. Bit 3 beats bit 2, which beats bit 1, which beats the CPU in bit 0.
- R4: Ownership changes only on the clock edge after a release point, that is, a cycle in which the owner's `cyc_end` is high and its `lock` is low. Without a release point the grant holds.
- R5: A `cyc_end` seen while the owner's `lock` is high is not a release point, whether it comes from a split access or a read-modify-write.
- R6: When the CPU owns the bus and `cpu_sleep` is high, a waiting request is granted on the next edge, whatever `cyc_end[0]` and `lock[0]` are.
- R7: `xc_phase` encodes the transfer controller's phase: 0 vector read, 1 register-information read, 2 data transfer, 3 register-information write. In phases 1 and 3, its `cyc_end` counts as a release point only on its REGINFO_STATES-th owned state in that phase (the 3rd by default). An earlier `cyc_end` is ignored. In phases 0 and 2, any unlocked `cyc_end` releases.
- R8: At a release point with no DMA-type request pending, ownership returns to the CPU. While nothing is requested, the CPU keeps the bus.
- R9: An owner that is still the highest requester keeps the bus across its release points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_MASTERS | Bus requests, index 0 is the CPU |
| cyc_end | input | NUM_MASTERS | Per-master strobe: current bus cycle ends this clock |
| lock | input | NUM_MASTERS | Per-master flag: current cycle belongs to an indivisible sequence |
| cpu_sleep | input | 1 | CPU is in sleep mode |
| xc_phase | input | 2 | Transfer controller phase code (see R7) |
| grant | output | NUM_MASTERS | One-hot bus ownership |

## Verification
The bench builds the block with its defaults: four masters, the transfer controller at index 1, and three states per register-information phase.

Four masters are enough to exercise every pairwise priority relation and a handover between two DMA-type masters, with a lower request still waiting. Three states keep the early-`cyc_end` case short, so both register-information phases can each be driven through an ignored strobe and then a legal release.

// File: rtl/boa_pkg.sv
// Shared types for the bus ownership arbiter.
// Assumes the transfer controller phase arrives as a 2-bit code.
package boa_pkg;

    typedef enum logic [1:0] {
        XP_VECTOR = 2'd0,
        XP_REG_RD = 2'd1,
        XP_DATA   = 2'd2,
        XP_REG_WR = 2'd3
    } xc_phase_e;

    // True for the phases whose length is counted in bus states.
    function automatic logic is_reginfo(input xc_phase_e ph);
        return (ph == XP_REG_RD) || (ph == XP_REG_WR);
    endfunction

endpackage

// File: rtl/boa_prio_pick.sv
// Fixed-priority picker: returns the highest requesting index, or 0 (CPU)
// when nothing is requested. Assumes a higher index means higher priority.
module boa_prio_pick #(
    parameter int NUM_MASTERS = 4,
    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] req,
    output logic [IDX_W-1:0]       best
);

    // Scan upward so that the last match, the highest index, wins.
    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req[i]) best = IDX_W'(i);
        end
    end

endmodule

// File: rtl/boa_xc_phase_guard.sv
// Counts the states the transfer controller has owned in a register-information
// phase, and reports when a cycle end there may release the bus.
// Assumes a register-information phase starts on the first owned state with
// that phase code, and that phases are separated by cycle ends.
module boa_xc_phase_guard
    import boa_pkg::*;
#(
    parameter int REGINFO_STATES = 3,
    localparam int CNT_W = $clog2(REGINFO_STATES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xc_owns,
    input  logic       cyc_end,
    input  logic       lock,
    input  logic [1:0] phase,
    output logic       phase_done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(REGINFO_STATES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             reginfo;

    // Decode whether the current phase is state-counted.
    always_comb begin
        reginfo    = is_reginfo(xc_phase_e'(phase));
        phase_done = !reginfo || (cnt_q == LAST);
    end

    // Advance the owned-state count; clear it on a completed phase or on loss of ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!xc_owns || !reginfo) begin
            cnt_q <= '0;
        end else if (cyc_end && !lock && phase_done) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/boa_release_gate.sv
// Per-master release point decode. The CPU may also release at once while
// asleep; the transfer controller needs its phase guard's approval.
module boa_release_gate #(
    parameter int NUM_MASTERS = 4,
    parameter int XC_INDEX    = 1
) (
    input  logic [NUM_MASTERS-1:0] cyc_end,
    input  logic [NUM_MASTERS-1:0] lock,
    input  logic                   cpu_sleep,
    input  logic                   xc_done,
    output logic [NUM_MASTERS-1:0] rel_pt
);

    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_rel
        if (i == 0) begin : g_cpu
            // CPU: unlocked cycle end, or any time while sleeping.
            assign rel_pt[i] = cpu_sleep | (cyc_end[i] & ~lock[i]);
        end else if (i == XC_INDEX) begin : g_xc
            // Transfer controller: unlocked cycle end at the end of a whole phase.
            assign rel_pt[i] = cyc_end[i] & ~lock[i] & xc_done;
        end else begin : g_dma
            // DMA-type master: any unlocked cycle end.
            assign rel_pt[i] = cyc_end[i] & ~lock[i];
        end
    end

endmodule

// File: rtl/bus_owner_arbiter.sv
// Top of the bus ownership arbiter. Holds the current owner and moves it to the
// highest requester only at the owner's release point, one edge later.
// Assumes master 0 is the CPU and is the default owner.
module bus_owner_arbiter #(
    parameter int NUM_MASTERS    = 4,
    parameter int XC_INDEX       = 1,
    parameter int REGINFO_STATES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [NUM_MASTERS-1:0] cyc_end,
    input  logic [NUM_MASTERS-1:0] lock,
    input  logic                   cpu_sleep,
    input  logic [1:0]             xc_phase,
    output logic [NUM_MASTERS-1:0] grant
);

    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
    localparam logic [IDX_W-1:0] XC_IDX = IDX_W'(XC_INDEX);

    logic [IDX_W-1:0]       owner_q;
    logic [IDX_W-1:0]       best;
    logic [NUM_MASTERS-1:0] rel_pt;
    logic                   xc_done;
    logic                   xc_owns;

    assign xc_owns = (owner_q == XC_IDX);

    boa_prio_pick #(.NUM_MASTERS(NUM_MASTERS)) i_pick (
        .req  (req),
        .best (best)
    );

    boa_xc_phase_guard #(.REGINFO_STATES(REGINFO_STATES)) i_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .xc_owns    (xc_owns),
        .cyc_end    (cyc_end[XC_INDEX]),
        .lock       (lock[XC_INDEX]),
        .phase      (xc_phase),
        .phase_done (xc_done)
    );

    boa_release_gate #(.NUM_MASTERS(NUM_MASTERS), .XC_INDEX(XC_INDEX)) i_gate (
        .cyc_end   (cyc_end),
        .lock      (lock),
        .cpu_sleep (cpu_sleep),
        .xc_done   (xc_done),
        .rel_pt    (rel_pt)
    );

    // Hand over to the best requester only at the owner's release point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
        end else if (rel_pt[owner_q] && (best != owner_q)) begin
            owner_q <= best;
        end
    end

    // Decode the owner index to a one-hot grant.
    always_comb begin
        grant          = '0;
        grant[owner_q] = 1'b1;
    end

endmodule

// File: rtl/boa_checker.sv
// Assertion checker for bus_owner_arbiter, bound to every instance.
module boa_checker #(
    parameter int NUM_MASTERS = 4,
    parameter int XC_INDEX    = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req,
    input logic [NUM_MASTERS-1:0] cyc_end,
    input logic [NUM_MASTERS-1:0] lock,
    input logic                   cpu_sleep,
    input logic [1:0]             xc_phase,
    input logic [NUM_MASTERS-1:0] grant
);

    logic [NUM_MASTERS-1:0] top_req_q;

    // Remember the one-hot highest requester of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_req_q <= NUM_MASTERS'(1);
        end else begin
            top_req_q <= NUM_MASTERS'(1);
            for (int i = 1; i < NUM_MASTERS; i++) begin
                if (req[i]) top_req_q <= NUM_MASTERS'(1) << i;
            end
        end
    end

    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1);

    a_r3_new_owner_is_top: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grant) |-> grant == top_req_q);

    a_r4_change_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grant) |-> ($past(|(grant & cyc_end & ~lock)) || $past(grant[0] && cpu_sleep)));

    a_r5_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(grant & lock)) && !(grant[0] && cpu_sleep)) |=> $stable(grant));

    a_r6_sleep_hands_over: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && cpu_sleep && (|req[NUM_MASTERS-1:1])) |=> !grant[0]);

    a_r7_reginfo_first_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[XC_INDEX] && !$past(grant[XC_INDEX]) && (xc_phase == 2'd1 || xc_phase == 2'd3))
        |=> grant[XC_INDEX]);

endmodule

bind bus_owner_arbiter boa_checker #(
    .NUM_MASTERS (NUM_MASTERS),
    .XC_INDEX    (XC_INDEX)
) i_boa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cyc_end   (cyc_end),
    .lock      (lock),
    .cpu_sleep (cpu_sleep),
    .xc_phase  (xc_phase),
    .grant     (grant)
);

// File: tb/test_bus_owner_arbiter.sv
// Directed bench for bus_owner_arbiter with default parameters.
module test_bus_owner_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] cyc_end = '0;
    logic [3:0] lock = '0;
    logic       cpu_sleep = 1'b0;
    logic [1:0] xc_phase = '0;
    logic [3:0] grant;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bus_owner_arbiter i_bus_owner_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .cyc_end   (cyc_end),
        .lock      (lock),
        .cpu_sleep (cpu_sleep),
        .xc_phase  (xc_phase),
        .grant     (grant)
    );

    always #5 clk = ~clk;

    // Apply one cycle of inputs at the falling edge, then return just after the rising edge.
    task automatic drive(input logic [3:0] r, input logic [3:0] ce, input logic [3:0] lk,
                         input logic s, input logic [1:0] ph);
        @(negedge clk);
        req = r; cyc_end = ce; lock = lk; cpu_sleep = s; xc_phase = ph;
        @(posedge clk);
        #1;
    endtask

    // Compare the grant; R2 one-hot is checked on every call.
    task automatic chk(input logic [3:0] exp, input string tag);
        total++;
        if (grant !== exp || $countones(grant) != 1) begin
            bad++;
            $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1 chk(4'b0001, "R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 chk(4'b0001, "R1 after reset");
    endtask

    task automatic t_priority;
        drive(4'b1110, 4'b0001, 4'b0000, 1'b0, 2'd0); chk(4'b1000, "R3 top wins from CPU");
        drive(4'b0110, 4'b1000, 4'b0000, 1'b0, 2'd0); chk(4'b0100, "R3 next level");
        drive(4'b0010, 4'b0100, 4'b0000, 1'b0, 2'd0); chk(4'b0010, "R3 transfer ctrl");
        drive(4'b0000, 4'b0010, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R8 back to CPU");
    endtask

    task automatic t_defer;
        drive(4'b1000, 4'b0000, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R4 no cycle end 1");
        drive(4'b1000, 4'b0000, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R4 no cycle end 2");
        drive(4'b1000, 4'b0001, 4'b0000, 1'b0, 2'd0); chk(4'b1000, "R4 at cycle end");
        drive(4'b0000, 4'b1000, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R8 release to CPU");
    endtask

    task automatic t_lock;
        drive(4'b0100, 4'b0001, 4'b0001, 1'b0, 2'd0); chk(4'b0001, "R5 CPU split word");
        drive(4'b0100, 4'b0001, 4'b0001, 1'b0, 2'd0); chk(4'b0001, "R5 CPU rmw");
        drive(4'b0100, 4'b0001, 4'b0000, 1'b0, 2'd0); chk(4'b0100, "R5 unlock releases");
        drive(4'b0000, 4'b0100, 4'b0100, 1'b0, 2'd0); chk(4'b0100, "R5 DMA locked");
        drive(4'b0000, 4'b0100, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R8 DMA done");
    endtask

    task automatic t_sleep;
        drive(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0); chk(4'b0001, "R8 idle sleep keeps CPU");
        drive(4'b0010, 4'b0000, 4'b0001, 1'b1, 2'd0); chk(4'b0010, "R6 sleep immediate");
        drive(4'b0000, 4'b0010, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R8 after sleep grant");
    endtask

    task automatic t_xc;
        drive(4'b0010, 4'b0001, 4'b0000, 1'b0, 2'd0); chk(4'b0010, "R3 xc acquires");
        drive(4'b1010, 4'b0010, 4'b0000, 1'b0, 2'd1); chk(4'b0010, "R7 read state1 end ignored");
        drive(4'b1010, 4'b0000, 4'b0000, 1'b0, 2'd1); chk(4'b0010, "R7 read state2");
        drive(4'b1010, 4'b0010, 4'b0000, 1'b0, 2'd1); chk(4'b1000, "R7 read state3 releases");
        drive(4'b0010, 4'b1000, 4'b0000, 1'b0, 2'd0); chk(4'b0010, "R3 xc again");
        drive(4'b0100, 4'b0010, 4'b0000, 1'b0, 2'd2); chk(4'b0100, "R7 data phase releases");
        drive(4'b0000, 4'b0100, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R8 idle");
        drive(4'b0010, 4'b0001, 4'b0000, 1'b0, 2'd3); chk(4'b0010, "R3 xc for write");
        drive(4'b0110, 4'b0010, 4'b0000, 1'b0, 2'd3); chk(4'b0010, "R7 write state1 ignored");
        drive(4'b0110, 4'b0010, 4'b0000, 1'b0, 2'd3); chk(4'b0010, "R7 write state2 ignored");
        drive(4'b0110, 4'b0010, 4'b0000, 1'b0, 2'd3); chk(4'b0100, "R7 write state3 releases");
        drive(4'b0000, 4'b0100, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R8 idle again");
    endtask

    task automatic t_keep;
        drive(4'b1000, 4'b0001, 4'b0000, 1'b0, 2'd0); chk(4'b1000, "R3 DMA acquires");
        drive(4'b1100, 4'b1000, 4'b0000, 1'b0, 2'd0); chk(4'b1000, "R9 top owner keeps");
        drive(4'b0100, 4'b1000, 4'b0000, 1'b0, 2'd0); chk(4'b0100, "R3 waiting lower gets it");
        drive(4'b0000, 4'b0100, 4'b0000, 1'b0, 2'd0); chk(4'b0001, "R8 final idle");
    endtask

    initial begin
        t_reset();
        t_priority();
        t_defer();
        t_lock();
        t_sleep();
        t_xc();
        t_keep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired grant=%b expected=finish", grant);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule